// File: doc/BRIEF.md
# Battery-Backed Memory Supply Supervisor

This block watches the supply of a battery-backed static memory and decides, one sample at a time, what the memory may do. A converter outside the block delivers the supply level as an unsigned millivolt code together with a one-cycle valid strobe. From that stream the supervisor works out three things. The first is whether host accesses are allowed. The second is whether the memory's inputs must be ignored and its data pins released to high impedance. The third is whether the storage array is fed from the backup cell instead of the external supply.

Only a confirmed crossing moves the block, meaning one that two consecutive valid samples agree on. A single glitch sample is ignored, and cycles without a valid strobe neither count nor break a pair. The backup cell ships isolated. A one-time arming latch connects it after the first confirmed healthy supply and keeps it connected until reset. If the supply collapses before the cell was ever armed, the block raises a sticky data-lost flag. The parameter `TOL_10PCT` selects the supply tolerance variant, and that choice moves the access and protect thresholds.

Top module: `nvs_supply_supervisor`

## Requirements
- R1: After reset, `access_ok`=0, `force_hiz`=1, `on_battery`=0, `batt_armed`=0 and `data_lost`=0.
- R2: In the protected state, two consecutive valid samples strictly above the full-operation level set `access_ok`. That level is 4500 mV when `TOL_10PCT`=1 and 4750 mV when it is 0. One such sample followed by a lower one does not grant access.
- R3: While `access_ok`=1, two consecutive valid samples strictly below the trip level clear `access_ok`. The trip level is 4370 mV when `TOL_10PCT`=1 and 4620 mV when it is 0. A single low sample between higher ones is ignored.
- R4: `force_hiz` is 1 exactly when `access_ok` is 0.
- R5: From either the access state or the protected state, two consecutive valid samples strictly below 3000 mV enter the backup state. There `access_ok`=0, and `on_battery`=1 provided `batt_armed` is 1.
- R6: Two consecutive valid samples strictly above 4250 mV set `batt_armed`. It then stays 1 until reset, whatever the supply does.
- R7: Entering the backup state while `batt_armed`=0 keeps `on_battery` at 0 and sets `data_lost`. `data_lost` stays 1 until reset.
- R8: In the backup state, two consecutive valid samples strictly above 3000 mV return the block to the protected state. `on_battery` drops to 0 and `access_ok` stays 0 until R2 is met afresh.
- R9: Cycles with `smp_vld`=0 change no output and no qualification history, so two valid samples separated by idle cycles still count as consecutive.
- R10: Each output reflects a confirmed crossing on the clock edge that captures the second qualifying sample, with no further latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_vld | input | 1 | Marks a cycle that carries a new supply sample |
| vcc_mv | input | MV_W | Supply level in millivolts, unsigned |
| access_ok | output | 1 | Host reads and writes are permitted |
| force_hiz | output | 1 | Memory inputs ignored, data pins released |
| on_battery | output | 1 | Storage array fed from the backup cell |
| batt_armed | output | 1 | Backup cell connected (freshness latch set) |
| data_lost | output | 1 | Supply collapsed before the cell was armed |

## Verification
The assertions assume that `vcc_mv` is only meaningful in a cycle where `smp_vld` is high, and they tie each output change to the sample captured on the edge before it. The stimulus therefore changes `vcc_mv` and `smp_vld` just after a rising edge and never in any other way. The stimulus runs both tolerance variants from the same stream. It uses directed sequences for single glitches, idle gaps between paired samples, thresholds that only one variant crosses, and collapse before arming. It then adds a pseudo-random sweep between 2000 and 5600 mV in which each level is held for one to three samples and valid cycles are mixed with idle ones.

// File: rtl/nvs_sup_pkg.sv
package nvs_sup_pkg;

  typedef enum logic [1:0] {
    ST_SUPPLY_OK = 2'd0,
    ST_GUARDED   = 2'd1,
    ST_BACKUP    = 2'd2
  } pwr_state_e;

  localparam int SWITCH_MV = 3000;
  localparam int ARM_MV    = 4250;

  // Qualifier slot indices
  localparam int Q_FULL   = 0;
  localparam int Q_TRIP   = 1;
  localparam int Q_DROP   = 2;
  localparam int Q_RISE   = 3;
  localparam int Q_ARM    = 4;
  localparam int Q_COUNT  = 5;

  function automatic int full_level_mv(bit tol10);
    return tol10 ? 4500 : 4750;
  endfunction

  function automatic int trip_level_mv(bit tol10);
    return tol10 ? 4370 : 4620;
  endfunction

endpackage

// File: rtl/nvs_cross_qual.sv
module nvs_cross_qual #(
  parameter int MV_W   = 16,
  parameter int THRESH = 3000,
  parameter bit ABOVE  = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_vld,
  input  logic [MV_W-1:0] level,
  output logic            hit
);

  localparam logic [MV_W-1:0] THR = MV_W'(THRESH);

  logic cond;
  logic seen_q;
  logic seen_d;

  // Direction chosen at elaboration
  generate
    if (ABOVE) begin : g_above
      assign cond = (level > THR);
    end else begin : g_below
      assign cond = (level < THR);
    end
  endgenerate

  always_comb begin
    seen_d = seen_q;
    if (smp_vld) seen_d = cond;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= seen_d;
  end

  // Confirmed only when this sample and the previous valid one agree
  assign hit = smp_vld & cond & seen_q;

endmodule

// File: rtl/nvs_fresh_latch.sv
module nvs_fresh_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_hit,
  input  logic batt_entry,
  output logic armed,
  output logic lost
);

  logic armed_q, armed_d;
  logic lost_q, lost_d;
  logic upd_en;

  assign upd_en = arm_hit | batt_entry;

  always_comb begin
    armed_d = armed_q | arm_hit;
    lost_d  = lost_q | (batt_entry & ~armed_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      lost_q  <= 1'b0;
    end else if (upd_en) begin
      armed_q <= armed_d;
      lost_q  <= lost_d;
    end
  end

  assign armed = armed_q;
  assign lost  = lost_q;

endmodule

// File: rtl/nvs_power_fsm.sv
module nvs_power_fsm
  import nvs_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit_full,
  input  logic       hit_trip,
  input  logic       hit_drop,
  input  logic       hit_rise,
  output pwr_state_e state,
  output logic       batt_entry
);

  pwr_state_e st_q, st_d;
  logic       st_en;

  always_comb begin
    st_d       = st_q;
    batt_entry = 1'b0;
    case (st_q)
      ST_GUARDED: begin
        if (hit_drop) begin
          st_d       = ST_BACKUP;
          batt_entry = 1'b1;
        end else if (hit_full) begin
          st_d = ST_SUPPLY_OK;
        end
      end
      ST_SUPPLY_OK: begin
        if (hit_drop) begin
          st_d       = ST_BACKUP;
          batt_entry = 1'b1;
        end else if (hit_trip) begin
          st_d = ST_GUARDED;
        end
      end
      ST_BACKUP: begin
        if (hit_rise) st_d = ST_GUARDED;
      end
      default: st_d = ST_GUARDED;
    endcase
  end

  assign st_en = hit_full | hit_trip | hit_drop | hit_rise | (st_q == pwr_state_e'(2'd3));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ST_GUARDED;
    else if (st_en) st_q <= st_d;
  end

  assign state = st_q;

endmodule

// File: rtl/nvs_supply_supervisor.sv
module nvs_supply_supervisor
  import nvs_sup_pkg::*;
#(
  parameter bit TOL_10PCT = 1'b1,
  parameter int MV_W      = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_vld,
  input  logic [MV_W-1:0] vcc_mv,
  output logic            access_ok,
  output logic            force_hiz,
  output logic            on_battery,
  output logic            batt_armed,
  output logic            data_lost
);

  localparam int FULL_MV = full_level_mv(TOL_10PCT);
  localparam int TRIP_MV = trip_level_mv(TOL_10PCT);

  localparam int QTHR [Q_COUNT] = '{FULL_MV, TRIP_MV, SWITCH_MV, SWITCH_MV, ARM_MV};
  localparam bit QUP  [Q_COUNT] = '{1'b1,    1'b0,    1'b0,      1'b1,      1'b1};

  // Reset: asserted at once, released after two edges
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end

  assign rst_int_n = rst_pipe[1];

  logic [Q_COUNT-1:0] hits;

  generate
    for (genvar g = 0; g < Q_COUNT; g++) begin : g_qual
      nvs_cross_qual #(
        .MV_W  (MV_W),
        .THRESH(QTHR[g]),
        .ABOVE (QUP[g])
      ) u_qual (
        .clk    (clk),
        .rst_n  (rst_int_n),
        .smp_vld(smp_vld),
        .level  (vcc_mv),
        .hit    (hits[g])
      );
    end
  endgenerate

  pwr_state_e state;
  logic       batt_entry;
  logic       armed;
  logic       lost;

  nvs_power_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .hit_full  (hits[Q_FULL]),
    .hit_trip  (hits[Q_TRIP]),
    .hit_drop  (hits[Q_DROP]),
    .hit_rise  (hits[Q_RISE]),
    .state     (state),
    .batt_entry(batt_entry)
  );

  nvs_fresh_latch u_fresh (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .arm_hit   (hits[Q_ARM]),
    .batt_entry(batt_entry),
    .armed     (armed),
    .lost      (lost)
  );

  assign access_ok  = (state == ST_SUPPLY_OK);
  assign force_hiz  = ~access_ok;
  assign on_battery = (state == ST_BACKUP) & armed;
  assign batt_armed = armed;
  assign data_lost  = lost;

endmodule

// File: rtl/nvs_supply_supervisor_chk.sv
module nvs_supply_supervisor_chk
  import nvs_sup_pkg::*;
#(
  parameter bit TOL_10PCT = 1'b1,
  parameter int MV_W      = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            smp_vld,
  input logic [MV_W-1:0] vcc_mv,
  input logic            access_ok,
  input logic            force_hiz,
  input logic            on_battery,
  input logic            batt_armed,
  input logic            data_lost
);

  localparam logic [MV_W-1:0] FULL_L = MV_W'(full_level_mv(TOL_10PCT));
  localparam logic [MV_W-1:0] TRIP_L = MV_W'(trip_level_mv(TOL_10PCT));
  localparam logic [MV_W-1:0] SW_L   = MV_W'(SWITCH_MV);
  localparam logic [MV_W-1:0] ARM_L  = MV_W'(ARM_MV);

  AST_ACCESS_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(access_ok) |-> ($past(smp_vld) && ($past(vcc_mv) > FULL_L)));  // R2

  AST_ACCESS_DROP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(access_ok) |-> ($past(smp_vld) && ($past(vcc_mv) < TRIP_L)));  // R3

  AST_BACKUP_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    on_battery |-> (force_hiz && !access_ok));  // R5

  AST_BACKUP_ENTRY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_battery) |-> ($past(vcc_mv) < SW_L));  // R5

  AST_BACKUP_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    on_battery |-> batt_armed);  // R6

  AST_ARM_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(batt_armed) |-> ($past(smp_vld) && ($past(vcc_mv) > ARM_L)));  // R6

  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    batt_armed |=> batt_armed);  // R6

  AST_LOST_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_lost) |-> (($past(vcc_mv) < SW_L) && !batt_armed && !on_battery));  // R7

  AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    data_lost |=> data_lost);  // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_vld) |-> ($stable(access_ok) && $stable(on_battery) && $stable(batt_armed)));  // R9

endmodule

bind nvs_supply_supervisor nvs_supply_supervisor_chk #(
  .TOL_10PCT(TOL_10PCT),
  .MV_W     (MV_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_vld   (smp_vld),
  .vcc_mv    (vcc_mv),
  .access_ok (access_ok),
  .force_hiz (force_hiz),
  .on_battery(on_battery),
  .batt_armed(batt_armed),
  .data_lost (data_lost)
);

// File: tb/nvs_supply_supervisor_bench.sv
module nvs_supply_supervisor_bench;

  logic        clk;
  logic        rst_n;
  logic        smp_vld;
  logic [15:0] vcc_mv;

  logic acc [2];
  logic hiz [2];
  logic bat [2];
  logic arm [2];
  logic lst [2];

  int    checks;
  int    errors;
  bit    done;
  string phase;

  // Index 1: ten-percent variant, index 0: five-percent variant
  nvs_supply_supervisor #(.TOL_10PCT(1'b1), .MV_W(16)) u_nvs_supply_supervisor (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .vcc_mv(vcc_mv),
    .access_ok(acc[1]), .force_hiz(hiz[1]), .on_battery(bat[1]),
    .batt_armed(arm[1]), .data_lost(lst[1])
  );

  nvs_supply_supervisor #(.TOL_10PCT(1'b0), .MV_W(16)) u_nvs_supply_supervisor_5 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .vcc_mv(vcc_mv),
    .access_ok(acc[0]), .force_hiz(hiz[0]), .on_battery(bat[0]),
    .batt_armed(arm[0]), .data_lost(lst[0])
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  // Reference model: 0 = access, 1 = protected, 2 = backup
  int m_st  [2];
  bit m_pf  [2];
  bit m_pt  [2];
  bit m_pd  [2];
  bit m_pr  [2];
  bit m_pa  [2];
  bit m_arm [2];
  bit m_lost[2];

  function automatic int lvl_full(int v);
    return (v == 1) ? 4500 : 4750;
  endfunction

  function automatic int lvl_trip(int v);
    return (v == 1) ? 4370 : 4620;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < 2; v++) begin
        m_st[v] = 1; m_pf[v] = 0; m_pt[v] = 0; m_pd[v] = 0;
        m_pr[v] = 0; m_pa[v] = 0; m_arm[v] = 0; m_lost[v] = 0;
      end
    end else if (smp_vld) begin
      for (int v = 0; v < 2; v++) begin
        int  mv;
        bit  cf, ct, cd, cr, ca;
        mv = int'(vcc_mv);
        cf = (mv > lvl_full(v)) && m_pf[v];
        ct = (mv < lvl_trip(v)) && m_pt[v];
        cd = (mv < 3000) && m_pd[v];
        cr = (mv > 3000) && m_pr[v];
        ca = (mv > 4250) && m_pa[v];
        m_pf[v] = (mv > lvl_full(v));
        m_pt[v] = (mv < lvl_trip(v));
        m_pd[v] = (mv < 3000);
        m_pr[v] = (mv > 3000);
        m_pa[v] = (mv > 4250);
        if (m_st[v] == 2) begin
          if (cr) m_st[v] = 1;
        end else if (cd) begin
          if (!m_arm[v]) m_lost[v] = 1;
          m_st[v] = 2;
        end else if (m_st[v] == 1 && cf) begin
          m_st[v] = 0;
        end else if (m_st[v] == 0 && ct) begin
          m_st[v] = 1;
        end
        if (ca) m_arm[v] = 1;
      end
    end
  end

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // Per-cycle comparison, away from the active edge (R10: no extra latency)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int v = 0; v < 2; v++) begin
        chk(phase, $sformatf("access_ok[v%0d]", v), int'(acc[v]), int'(m_st[v] == 0));
        chk("R4", $sformatf("force_hiz[v%0d]", v), int'(hiz[v]), int'(m_st[v] != 0));
        chk("R5", $sformatf("on_battery[v%0d]", v), int'(bat[v]), int'(m_st[v] == 2 && m_arm[v]));
        chk("R6", $sformatf("batt_armed[v%0d]", v), int'(arm[v]), int'(m_arm[v]));
        chk("R7", $sformatf("data_lost[v%0d]", v), int'(lst[v]), int'(m_lost[v]));
      end
    end
  end

  task automatic put(int mv, bit vld);
    @(posedge clk);
    #1;
    vcc_mv  = 16'(mv);
    smp_vld = vld;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) put(int'(vcc_mv), 1'b0);
  endtask

  task automatic pulse_reset();
    @(posedge clk);
    #1;
    rst_n   = 1'b0;
    smp_vld = 1'b0;
    #3;
    for (int v = 0; v < 2; v++) begin
      chk("R1", "reset access_ok", int'(acc[v]), 0);
      chk("R1", "reset force_hiz", int'(hiz[v]), 1);
      chk("R1", "reset on_battery", int'(bat[v]), 0);
      chk("R1", "reset batt_armed", int'(arm[v]), 0);
      chk("R1", "reset data_lost", int'(lst[v]), 0);
    end
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    idle(4);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got 0 expected 1 (run ended)");
      finish_run();
    end
  end

  initial begin
    int unsigned seed;
    checks  = 0;
    errors  = 0;
    done    = 1'b0;
    phase   = "R1";
    rst_n   = 1'b0;
    smp_vld = 1'b0;
    vcc_mv  = 16'd0;
    pulse_reset();

    // R9: idle cycles with a high level do nothing
    phase = "R9";
    put(5200, 1'b0);
    idle(5);
    chk("R9", "idle access_ok", int'(acc[1]), 0);

    // R6: arm without reaching access level
    phase = "R6";
    put(4300, 1'b1);
    put(4300, 1'b1);
    idle(1);
    chk("R6", "armed after 4300x2", int'(arm[1]), 1);
    chk("R6", "no access at 4300", int'(acc[1]), 0);

    // R2: single high sample does not grant; pair only for the 10% variant
    phase = "R2";
    put(4600, 1'b1);
    put(4400, 1'b1);
    put(4600, 1'b1);
    idle(3);          // R9: gap between the two samples of a pair
    put(4600, 1'b1);
    idle(1);
    chk("R2", "10pct access at 4600x2", int'(acc[1]), 1);
    chk("R2", "5pct no access at 4600x2", int'(acc[0]), 0);
    put(4800, 1'b1);
    put(4800, 1'b1);
    idle(1);
    chk("R2", "5pct access at 4800x2", int'(acc[0]), 1);

    // R3: single glitch ignored, then per-variant trip
    phase = "R3";
    put(4000, 1'b1);
    put(4800, 1'b1);
    idle(1);
    chk("R3", "glitch ignored", int'(acc[1]), 1);
    put(4600, 1'b1);
    put(4600, 1'b1);
    idle(1);
    chk("R3", "5pct dropped at 4600", int'(acc[0]), 0);
    chk("R3", "10pct kept at 4600", int'(acc[1]), 1);
    put(4300, 1'b1);
    put(4300, 1'b1);
    idle(1);
    chk("R3", "10pct dropped at 4300", int'(acc[1]), 0);

    // R5: collapse onto backup while armed
    phase = "R5";
    put(2900, 1'b1);
    put(2900, 1'b1);
    idle(1);
    chk("R5", "on battery", int'(bat[1]), 1);

    // R8: recover to protected, then resume only above full level
    phase = "R8";
    put(3100, 1'b1);
    put(3100, 1'b1);
    idle(1);
    chk("R8", "battery released", int'(bat[1]), 0);
    chk("R8", "still no access", int'(acc[1]), 0);
    put(4800, 1'b1);
    put(4800, 1'b1);
    idle(1);
    chk("R8", "access after full", int'(acc[0]), 1);

    // R7: collapse before arming
    phase = "R7";
    pulse_reset();
    put(2500, 1'b1);
    put(2500, 1'b1);
    idle(1);
    chk("R7", "data lost set", int'(lst[1]), 1);
    chk("R7", "battery not selected", int'(bat[1]), 0);
    put(5000, 1'b1);
    put(5000, 1'b1);
    put(5000, 1'b1);
    idle(1);
    chk("R7", "lost stays set", int'(lst[0]), 1);

    // R10: pseudo-random sweep against the model every cycle
    phase = "R10";
    seed  = 32'h1357_2468;
    for (int n = 0; n < 700; n++) begin
      int mv;
      int hold;
      seed = seed * 32'd1103515245 + 32'd12345;
      mv   = 2000 + int'((seed >> 8) % 32'd3600);
      hold = 1 + int'((seed >> 20) % 32'd3);
      for (int h = 0; h < hold; h++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        put(mv, ((seed >> 16) & 32'd3) != 0);
      end
    end
    idle(2);
    finish_run();
  end

endmodule